// File: doc/BRIEF.md
# PCM Codec Serial Port

This block connects a voice codec's synchronous serial link to a parallel sample-processing core. The codec supplies a bit clock, a short frame-marker pulse, and a serial input line. The block runs on the chip's own system clock and oversamples all three lines. It collects one 16-bit sample per frame from the input line. It hands that sample to the core as a parallel word with a single-cycle valid strobe. In the same frame it serialises one 16-bit word from the core back onto the output line. Both directions send the most significant bit first.

A frame is accepted only when the marker pulse encloses exactly one falling bit-clock edge. When the marker ends, the block checks how many falling edges it saw. It then either starts shifting or rejects the pulse and sets a sticky error flag. A separate request strobe, raised once per accepted frame, tells the core that the next transmit word is wanted. A bypass input connects the serial input straight to the serial output and holds the core stopped.

The frame control is a three-state machine. IDLE waits for the marker to rise (transition IDLE→MARK). MARK counts falling bit-clock edges while the marker is high. When the marker falls, MARK either accepts the frame (MARK→SHIFT) or rejects it (MARK→IDLE). In SHIFT, each falling bit-clock edge samples one input bit, and the sixteenth sample completes the frame (SHIFT→IDLE). A new marker arriving in SHIFT abandons the partial frame (SHIFT→MARK). Bypass forces MARK or SHIFT back to IDLE and keeps the machine in IDLE.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, rx_valid, tx_req, frame_err, rx_data and pcm_dout are all 0.
- R2: A marker pulse that encloses exactly one falling edge of pcm_mclk is accepted. At acceptance, tx_req pulses high for exactly one system clock.
- R3: After an accepted marker, pcm_din is sampled on each of the next 16 falling pcm_mclk edges. The first sample becomes bit 15 of rx_data and the last becomes bit 0. rx_valid pulses for one system clock when rx_data is updated after the 16th sample.
- R4: At acceptance, bit 15 of the loaded transmit word appears on pcm_dout. Each later rising pcm_mclk edge puts out the next lower bit, so bit 15-k is on the line during the (k+1)-th falling edge.
- R5: tx_we stores tx_data as the pending word. At acceptance the pending word is loaded and used up. If nothing has been written since the previous acceptance, sixteen zeros are sent.
- R6: A marker pulse with no falling pcm_mclk edge produces no tx_req and no rx_valid, and it sets frame_err.
- R7: A marker pulse with two falling pcm_mclk edges produces no tx_req and no rx_valid, and it sets frame_err.
- R8: Once set, frame_err stays at 1 until reset, while later valid frames are still processed normally.
- R9: While bypass is 1, pcm_dout equals pcm_din combinationally, core_stop is 1, and no rx_valid or tx_req is produced.
- R10: A marker rising during the 16-bit shift abandons that frame without rx_valid. The new marker is then handled as a fresh frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pcm_mclk | input | 1 | Codec bit clock (asynchronous) |
| pcm_fs | input | 1 | Codec frame marker pulse (asynchronous) |
| pcm_din | input | 1 | Serial sample from codec |
| pcm_dout | output | 1 | Serial sample to codec |
| bypass | input | 1 | 1 routes pcm_din to pcm_dout and stops the core |
| core_stop | output | 1 | Hold request for the processing core |
| rx_data | output | 16 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe: rx_data updated |
| tx_data | input | 16 | Next sample to transmit |
| tx_we | input | 1 | Stores tx_data as the pending word |
| tx_req | output | 1 | One-cycle strobe: frame accepted, next word wanted |
| frame_err | output | 1 | Sticky: a marker pulse was rejected |

## Verification
The assertions assume that the bit clock and the marker each stay at a level for several system clocks. This lets each edge be seen once after synchronisation. They also assume that the marker never rises and falls inside one synchronised cycle. The stimulus holds every codec-side level for at least four system clocks. It changes pcm_din only while pcm_mclk is high, well clear of the sampling edge. It raises and lowers the marker only while the bit clock is high, so that each accepted marker encloses exactly the falls the test intends.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_SHIFT
    } frame_state_e;

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pcm_frame_fsm.sv
module pcm_frame_fsm
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bypass,
    input  logic                mclk_s,
    input  logic                fs_s,
    input  logic                din_s,
    output logic                accept,
    output logic                shift_rise,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid,
    output logic                frame_err
);

    localparam int CNT_W = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

    frame_state_e state_q, state_n;

    logic                mclk_d, fs_d;
    logic                mclk_fall, mclk_rise, fs_rise, fs_fall;
    logic [1:0]          falls_q, falls_now;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [SAMPLE_W-2:0] rx_sh_q;
    logic                bad_mark, bit_take, last_bit;

    assign mclk_fall = mclk_d & ~mclk_s;
    assign mclk_rise = ~mclk_d & mclk_s;
    assign fs_rise   = ~fs_d & fs_s;
    assign fs_fall   = fs_d & ~fs_s;

    assign falls_now = (mclk_fall && falls_q != 2'd2) ? falls_q + 2'd1 : falls_q;

    assign accept     = (state_q == ST_MARK) && !bypass && fs_fall && (falls_now == 2'd1);
    assign bad_mark   = (state_q == ST_MARK) && !bypass && fs_fall && (falls_now != 2'd1);
    assign bit_take   = (state_q == ST_SHIFT) && !bypass && !fs_rise && mclk_fall;
    assign last_bit   = bit_take && (bit_cnt_q == LAST_BIT);
    assign shift_rise = (state_q == ST_SHIFT) && !bypass && mclk_rise;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!bypass && fs_rise) state_n = ST_MARK;
            end
            ST_MARK: begin
                if (bypass)        state_n = ST_IDLE;
                else if (fs_fall)  state_n = (falls_now == 2'd1) ? ST_SHIFT : ST_IDLE;
            end
            ST_SHIFT: begin
                if (bypass)        state_n = ST_IDLE;
                else if (fs_rise)  state_n = ST_MARK;
                else if (last_bit) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_d    <= 1'b0;
            fs_d      <= 1'b0;
            falls_q   <= '0;
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            mclk_d    <= mclk_s;
            fs_d      <= fs_s;
            rx_valid  <= last_bit;
            frame_err <= frame_err | bad_mark;
            if (state_n == ST_MARK && state_q != ST_MARK) begin
                falls_q <= '0;
            end else if (state_q == ST_MARK) begin
                falls_q <= falls_now;
            end
            if (accept) begin
                bit_cnt_q <= '0;
            end else if (bit_take) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                rx_sh_q   <= {rx_sh_q[SAMPLE_W-3:0], din_s};
            end
            if (last_bit) rx_data <= {rx_sh_q, din_s};
        end
    end

    p_rx_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_rx_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(mclk_fall));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> ($past(state_q) == ST_MARK) && $past(fs_fall));

    p_bypass_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> !rx_valid && state_q == ST_IDLE);

    p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && $past(state_q) != ST_SHIFT) |-> $past(fs_fall));

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                tx_we,
    input  logic                load,
    input  logic                shift_rise,
    output logic                tx_bit,
    output logic                tx_req
);

    localparam int SENT_W = $clog2(SAMPLE_W + 1);
    localparam logic [SENT_W-1:0] ALL_SENT = SENT_W'(SAMPLE_W);

    logic [SAMPLE_W-1:0] pend_q, sh_q, word;
    logic                fresh_q;
    logic [SENT_W-1:0]   sent_q;

    assign word = fresh_q ? pend_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            fresh_q <= 1'b0;
            sh_q    <= '0;
            sent_q  <= ALL_SENT;
            tx_bit  <= 1'b0;
            tx_req  <= 1'b0;
        end else begin
            tx_req <= load;
            if (tx_we) begin
                pend_q  <= tx_data;
                fresh_q <= 1'b1;
            end else if (load) begin
                fresh_q <= 1'b0;
            end
            if (load) begin
                tx_bit <= word[SAMPLE_W-1];
                sh_q   <= word << 1;
                sent_q <= SENT_W'(1);
            end else if (shift_rise && sent_q < ALL_SENT) begin
                tx_bit <= sh_q[SAMPLE_W-1];
                sh_q   <= sh_q << 1;
                sent_q <= sent_q + 1'b1;
            end
        end
    end

    p_tx_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    p_sent_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sent_q <= ALL_SENT);

    p_req_follows_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tx_req && !fresh_q || $past(tx_we));

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pcm_mclk,
    input  logic                pcm_fs,
    input  logic                pcm_din,
    output logic                pcm_dout,
    input  logic                bypass,
    output logic                core_stop,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                tx_we,
    output logic                tx_req,
    output logic                frame_err
);

    logic [2:0] line_s;
    logic       accept, shift_rise, tx_bit;

    pcm_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pcm_mclk, pcm_fs, pcm_din}),
        .sync_out (line_s)
    );

    pcm_frame_fsm #(
        .SAMPLE_W (SAMPLE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass     (bypass),
        .mclk_s     (line_s[2]),
        .fs_s       (line_s[1]),
        .din_s      (line_s[0]),
        .accept     (accept),
        .shift_rise (shift_rise),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .frame_err  (frame_err)
    );

    pcm_tx_path #(
        .SAMPLE_W (SAMPLE_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_data    (tx_data),
        .tx_we      (tx_we),
        .load       (accept),
        .shift_rise (shift_rise),
        .tx_bit     (tx_bit),
        .tx_req     (tx_req)
    );

    assign pcm_dout  = bypass ? pcm_din : tx_bit;
    assign core_stop = bypass;

    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_stop |=> !tx_req);

endmodule

// File: tb/test_pcm_serial_port.sv
`timescale 1ns/1ps
module test_pcm_serial_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pcm_mclk = 1'b1;
    logic        pcm_fs = 1'b0;
    logic        pcm_din = 1'b0;
    logic        bypass = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_we = 1'b0;
    logic        pcm_dout, core_stop, rx_valid, tx_req, frame_err;
    logic [15:0] rx_data;

    int checks = 0;
    int fails  = 0;
    int n_rx   = 0;
    int n_req  = 0;

    always #2.5 clk = ~clk;

    pcm_serial_port i_pcm_serial_port (
        .clk(clk), .rst_n(rst_n), .pcm_mclk(pcm_mclk), .pcm_fs(pcm_fs),
        .pcm_din(pcm_din), .pcm_dout(pcm_dout), .bypass(bypass),
        .core_stop(core_stop), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_we(tx_we), .tx_req(tx_req), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) n_rx++;
            if (tx_req)   n_req++;
        end
    end

    // {write pending word, word on pcm_din, word for tx_data}
    localparam logic [32:0] VEC [5] = '{
        {1'b1, 16'hA5C3, 16'h1234},
        {1'b1, 16'hFFFF, 16'h8001},
        {1'b0, 16'h0001, 16'hDEAD},
        {1'b1, 16'h8000, 16'h0000},
        {1'b1, 16'h5A5A, 16'hFFFF}
    };

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_tx(input logic [15:0] w);
        tx_data = w;
        tx_we   = 1'b1;
        ticks(1);
        tx_we   = 1'b0;
        ticks(1);
    endtask

    task automatic run_frame(input logic [15:0] word, input int nfalls, input int nbits,
                             output logic [15:0] dword);
        dword  = '0;
        pcm_fs = 1'b1;
        ticks(8);
        for (int f = 0; f < nfalls; f++) begin
            pcm_mclk = 1'b0; ticks(8);
            pcm_mclk = 1'b1; ticks(8);
        end
        pcm_fs = 1'b0;
        ticks(8);
        for (int i = 15; i >= 16 - nbits; i--) begin
            pcm_din = word[i];
            ticks(4);
            dword[i] = pcm_dout;
            ticks(4);
            pcm_mclk = 1'b0; ticks(8);
            pcm_mclk = 1'b1; ticks(8);
        end
        ticks(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int rx0, rq0;
        ticks(4);
        // R1 reset state
        check("R1 rx_valid", 32'(rx_valid), 0);
        check("R1 tx_req", 32'(tx_req), 0);
        check("R1 frame_err", 32'(frame_err), 0);
        check("R1 rx_data", 32'(rx_data), 0);
        check("R1 pcm_dout", 32'(pcm_dout), 0);
        rst_n = 1'b1;
        ticks(4);

        // table walk: R2 R3 R4 R5
        for (int v = 0; v < 5; v++) begin
            logic [15:0] exp_tx;
            rx0 = n_rx; rq0 = n_req;
            if (VEC[v][32]) write_tx(VEC[v][15:0]);
            exp_tx = VEC[v][32] ? VEC[v][15:0] : 16'h0000;
            run_frame(VEC[v][31:16], 1, 16, d);
            check("R2 one tx_req per frame", 32'(n_req - rq0), 1);
            check("R3 one rx_valid per frame", 32'(n_rx - rx0), 1);
            check("R3 rx_data", 32'(rx_data), 32'(VEC[v][31:16]));
            check("R4 R5 dout word", 32'(d), 32'(exp_tx));
        end

        // R6 marker with no falling edge
        rx0 = n_rx; rq0 = n_req;
        run_frame(16'h0, 0, 0, d);
        check("R6 no tx_req", 32'(n_req - rq0), 0);
        check("R6 no rx_valid", 32'(n_rx - rx0), 0);
        check("R6 frame_err", 32'(frame_err), 1);

        // R7 marker with two falling edges (reset first to clear the flag)
        rst_n = 1'b0; ticks(2); rst_n = 1'b1; ticks(2);
        check("R7 err cleared by reset", 32'(frame_err), 0);
        rx0 = n_rx; rq0 = n_req;
        run_frame(16'h0, 2, 0, d);
        check("R7 no tx_req", 32'(n_req - rq0), 0);
        check("R7 no rx_valid", 32'(n_rx - rx0), 0);
        check("R7 frame_err", 32'(frame_err), 1);

        // R8 sticky flag, valid frame still handled
        write_tx(16'hC0DE);
        rx0 = n_rx;
        run_frame(16'h3C3C, 1, 16, d);
        check("R8 frame_err stays", 32'(frame_err), 1);
        check("R8 rx_data", 32'(rx_data), 32'h3C3C);
        check("R8 dout word", 32'(d), 32'hC0DE);
        check("R8 rx_valid", 32'(n_rx - rx0), 1);

        // R10 abort mid-frame
        rx0 = n_rx; rq0 = n_req;
        run_frame(16'hFFFF, 1, 5, d);
        run_frame(16'h1357, 1, 16, d);
        check("R10 single rx_valid", 32'(n_rx - rx0), 1);
        check("R10 rx_data new frame", 32'(rx_data), 32'h1357);
        check("R10 two tx_req", 32'(n_req - rq0), 2);

        // R9 bypass
        bypass = 1'b1;
        pcm_din = 1'b1; ticks(1);
        check("R9 dout follows din high", 32'(pcm_dout), 1);
        check("R9 core_stop", 32'(core_stop), 1);
        pcm_din = 1'b0; #1;
        check("R9 dout follows din low", 32'(pcm_dout), 0);
        ticks(1);
        rx0 = n_rx; rq0 = n_req;
        run_frame(16'h9A61, 1, 16, d);
        check("R9 dout equals din word", 32'(d), 32'h9A61);
        check("R9 no rx_valid", 32'(n_rx - rx0), 0);
        check("R9 no tx_req", 32'(n_req - rq0), 0);
        bypass = 1'b0;
        ticks(2);
        check("R9 core_stop released", 32'(core_stop), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule